// File: doc/BRIEF.md
# Framed B-Channel Serial Port

This block moves two 8-bit B channels over a serial data line once per 8 kHz frame. Each channel sits in its own time slot, and each slot has its own sync strobe. The slot 1 strobe marks the start of the frame, and the slot 2 strobe marks the start of the second byte. Transmit bytes come from two parallel registers and leave the block MSB first. Received bytes are shifted in and latched into two parallel registers. A one-cycle flag pulses each time a byte has been latched.

The block runs on a fast system clock. As timing master, it divides that clock down to a bit clock and drives the bit clock and both strobes. As timing slave, it takes all three from outside through a synchronizer and works from the bit-clock edges it detects. Two options change the framing. One option moves the data one bit period later than the strobe. The other option swaps which parallel register pair serves each slot. Outside the two slots the data output is released.

Top module: `bchan_serial_port`

## Requirements
- R1: When `cfg_clk_master`=1, `bitclk_o` has a period of 2*max(1, HALF0>>c) system clocks, where c is `cfg_clk_sel`, and codes above 4 act as 4. A frame is 32<<c bit periods (code 0 gives 32 bits at 256 kHz, code 1 gives 64 bits at 512 kHz).
- R2: When `cfg_clk_master`=0, `timing_oe` is 0 and `bitclk_o`, `slot1_sync_o` and `slot2_sync_o` stay 0. The frame timing then follows `bitclk_i`, `slot1_sync_i` and `slot2_sync_i`.
- R3: When `cfg_clk_master`=1, each strobe is high for exactly one bit period and changes only on a bit-clock rising edge. The slot 2 strobe rises 8 bit periods after the slot 1 strobe, and the two strobes are never high together.
- R4: When `cfg_late_data`=0, a slot's first bit is driven from the bit-clock rising edge at which its strobe goes high. The master raises slot 1 at frame bit 0 and slot 2 at bit 8.
- R5: When `cfg_late_data`=1, a strobe sampled high on a falling edge starts its slot at the next rising edge. The master raises slot 1 during the last bit of the previous frame and slot 2 during bit 7.
- R6: Data is sent MSB first and `ser_do` changes only on bit-clock rising edges. `ser_di` is sampled on falling edges.
- R7: When `cfg_swap_ch`=0, slot 1 uses `tx_b1`/`rx_b1` and slot 2 uses `tx_b2`/`rx_b2`. When it is 1, slot 1 uses `tx_b2`/`rx_b2` and slot 2 uses `tx_b1`/`rx_b1`.
- R8: After the 8th bit of a slot is sampled, the byte is written to its RX register and that register's valid flag is high for exactly one system clock. Each RX register changes only while its flag is high.
- R9: `ser_doe` is 1 during the 8 bit periods of each slot and 0 at every other bit position.
- R10: After reset, the RX registers, the valid flags, `ser_doe` and the master timing outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_master | input | 1 | 1: generate bit clock and strobes; 0: accept them |
| cfg_late_data | input | 1 | 1: data one bit period after strobe |
| cfg_swap_ch | input | 1 | 1: exchange the channel registers between slots |
| cfg_clk_sel | input | 3 | Bit-clock rate code in master mode |
| tx_b1 | input | 8 | Transmit byte, channel 1 |
| tx_b2 | input | 8 | Transmit byte, channel 2 |
| rx_b1 | output | 8 | Received byte, channel 1 |
| rx_b2 | output | 8 | Received byte, channel 2 |
| rx_b1_vld | output | 1 | One-cycle pulse when rx_b1 is written |
| rx_b2_vld | output | 1 | One-cycle pulse when rx_b2 is written |
| bitclk_i | input | 1 | External bit clock (slave) |
| slot1_sync_i | input | 1 | External slot 1 strobe (slave) |
| slot2_sync_i | input | 1 | External slot 2 strobe (slave) |
| bitclk_o | output | 1 | Generated bit clock (master) |
| slot1_sync_o | output | 1 | Generated slot 1 strobe (master) |
| slot2_sync_o | output | 1 | Generated slot 2 strobe (master) |
| timing_oe | output | 1 | Output enable for the bit clock and strobes |
| ser_di | input | 1 | Serial receive data |
| ser_do | output | 1 | Serial transmit data |
| ser_doe | output | 1 | Serial output enable (0 = high impedance) |

## Verification
The hardest case to reach is the delayed-phase handover. Here the strobe sits in the last bit of the previous frame, and slot 2 begins at the same rising edge that ends slot 1. A single wrong bit count would move a whole byte or leave the line enabled. The bench acts as the far end. It follows the strobes and the bit clock as the requirements define them, drives its own bytes and captures the line. It runs table vectors that cross every rate code, including a clamped code, with both phases and both channel orders. Then it drives the slave inputs by hand, bit by bit, so that the synchronized input path is also covered in both phases.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int unsigned BASE_BITS  = 32;  // bits per frame at rate code 0
    localparam int unsigned RATE_MAX   = 4;   // highest distinct rate code
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned FCNT_W     = $clog2(BASE_BITS << RATE_MAX);

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_ONE  = 2'd1,
        SLOT_TWO  = 2'd2
    } slot_e;

    function automatic logic [2:0] clamp_rate(input logic [2:0] code);
        return (code > 3'(RATE_MAX)) ? 3'(RATE_MAX) : code;
    endfunction
endpackage

// File: rtl/bsp_clkgen.sv
module bsp_clkgen
    import bsp_pkg::*;
#(
    parameter int unsigned HALF0 = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       late,
    input  logic [2:0] rate,
    output logic       rise_o,
    output logic       fall_o,
    output logic       s1_nx,
    output logic       s2_nx,
    output logic       bclk_q_o,
    output logic       s1_q_o,
    output logic       s2_q_o
);
    localparam int unsigned DIV_W = $clog2(HALF0 + 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              bclk;
        logic [FCNT_W-1:0] fcnt;
        logic              s1;
        logic              s2;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [DIV_W-1:0]  half_m1;
    logic [FCNT_W-1:0] frame_last;
    logic [2:0]        code;

    always_comb begin
        int unsigned h;
        code = clamp_rate(rate);
        h = HALF0 >> code;
        if (h == 0) h = 1;
        half_m1    = DIV_W'(h - 1);
        frame_last = FCNT_W'((BASE_BITS << code) - 1);
    end

    always_comb begin
        gen_d  = gen_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (!en) begin
            gen_d.div  = '0;
            gen_d.bclk = 1'b0;
            gen_d.fcnt = '1;
            gen_d.s1   = 1'b0;
            gen_d.s2   = 1'b0;
        end else if (gen_q.div >= half_m1) begin
            gen_d.div  = '0;
            gen_d.bclk = !gen_q.bclk;
            if (!gen_q.bclk) begin
                rise_o     = 1'b1;
                gen_d.fcnt = (gen_q.fcnt >= frame_last) ? '0 : gen_q.fcnt + 1'b1;
                if (late) begin
                    gen_d.s1 = (gen_d.fcnt == frame_last);
                    gen_d.s2 = (gen_d.fcnt == FCNT_W'(BYTE_W - 1));
                end else begin
                    gen_d.s1 = (gen_d.fcnt == '0);
                    gen_d.s2 = (gen_d.fcnt == FCNT_W'(BYTE_W));
                end
            end else begin
                fall_o = 1'b1;
            end
        end else begin
            gen_d.div = gen_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q.div  <= '0;
            gen_q.bclk <= 1'b0;
            gen_q.fcnt <= '1;
            gen_q.s1   <= 1'b0;
            gen_q.s2   <= 1'b0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign s1_nx    = gen_d.s1;
    assign s2_nx    = gen_d.s2;
    assign bclk_q_o = gen_q.bclk;
    assign s1_q_o   = gen_q.s1;
    assign s2_q_o   = gen_q.s2;

    // R2
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !gen_q.bclk);
    // R3
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_q.s1 && gen_q.s2));
    // R3
    strobe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rise_o) |=> ($stable(gen_q.s1) && $stable(gen_q.s2)));
endmodule

// File: rtl/bsp_in_sync.sv
module bsp_in_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    logic [STAGES:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout  = chain_q[STAGES-1];
    assign dprev = chain_q[STAGES];
endmodule

// File: rtl/bsp_slot_engine.sv
module bsp_slot_engine
    import bsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              sync1,
    input  logic              sync2,
    input  logic              sdi,
    input  logic              late,
    input  logic              swap,
    input  logic [BYTE_W-1:0] tx1,
    input  logic [BYTE_W-1:0] tx2,
    output logic              sdo,
    output logic              sdoe,
    output logic [BYTE_W-1:0] rx1,
    output logic [BYTE_W-1:0] rx2,
    output logic              v1,
    output logic              v2
);
    localparam int unsigned BIT_W = $clog2(BYTE_W);

    typedef struct packed {
        slot_e             slot;
        logic              chan;   // 0: channel 1 registers, 1: channel 2
        logic [BIT_W-1:0]  bitn;
        logic [BYTE_W-1:0] txsh;
        logic [BYTE_W-1:0] rxsh;
        logic              sdo;
        logic              oe;
        logic              seen1;
        logic              seen2;
        logic [BYTE_W-1:0] rx1;
        logic [BYTE_W-1:0] rx2;
        logic              v1;
        logic              v2;
    } eng_t;

    eng_t eng_d, eng_q;
    logic start1, start2;
    logic [BYTE_W-1:0] rx_next;

    always_comb begin
        start1 = late ? eng_q.seen1 : (sync1 && !eng_q.seen1);
        start2 = late ? eng_q.seen2 : (sync2 && !eng_q.seen2);
    end

    always_comb begin
        eng_d    = eng_q;
        eng_d.v1 = 1'b0;
        eng_d.v2 = 1'b0;
        rx_next  = {eng_q.rxsh[BYTE_W-2:0], sdi};

        if (fall) begin
            eng_d.seen1 = sync1;
            eng_d.seen2 = sync2;
            if (eng_q.slot != SLOT_IDLE) begin
                eng_d.rxsh = rx_next;
                if (eng_q.bitn == BIT_W'(BYTE_W - 1)) begin
                    if (!eng_q.chan) begin
                        eng_d.rx1 = rx_next;
                        eng_d.v1  = 1'b1;
                    end else begin
                        eng_d.rx2 = rx_next;
                        eng_d.v2  = 1'b1;
                    end
                end
            end
        end

        if (rise) begin
            if (start1) begin
                eng_d.slot = SLOT_ONE;
                eng_d.chan = swap;
                eng_d.bitn = '0;
                eng_d.txsh = swap ? tx2 : tx1;
                eng_d.sdo  = eng_d.txsh[BYTE_W-1];
                eng_d.oe   = 1'b1;
            end else if (start2) begin
                eng_d.slot = SLOT_TWO;
                eng_d.chan = !swap;
                eng_d.bitn = '0;
                eng_d.txsh = swap ? tx1 : tx2;
                eng_d.sdo  = eng_d.txsh[BYTE_W-1];
                eng_d.oe   = 1'b1;
            end else if (eng_q.slot != SLOT_IDLE) begin
                if (eng_q.bitn == BIT_W'(BYTE_W - 1)) begin
                    eng_d.slot = SLOT_IDLE;
                    eng_d.oe   = 1'b0;
                    eng_d.sdo  = 1'b0;
                end else begin
                    eng_d.bitn = eng_q.bitn + 1'b1;
                    eng_d.txsh = {eng_q.txsh[BYTE_W-2:0], 1'b0};
                    eng_d.sdo  = eng_q.txsh[BYTE_W-2];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sdo  = eng_q.sdo;
    assign sdoe = eng_q.oe;
    assign rx1  = eng_q.rx1;
    assign rx2  = eng_q.rx2;
    assign v1   = eng_q.v1;
    assign v2   = eng_q.v2;

    // R6
    data_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> ($stable(sdo) && $stable(sdoe)));
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 || v2) |=> !(v1 || v2));
    // R8
    valid_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({v1, v2}));
    // R8
    rx1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v1 |-> $stable(rx1));
    // R8
    rx2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v2 |-> $stable(rx2));
endmodule

// File: rtl/bchan_serial_port.sv
module bchan_serial_port
    import bsp_pkg::*;
#(
    parameter int unsigned HALF0       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_clk_master,
    input  logic        cfg_late_data,
    input  logic        cfg_swap_ch,
    input  logic [2:0]  cfg_clk_sel,
    input  logic [7:0]  tx_b1,
    input  logic [7:0]  tx_b2,
    output logic [7:0]  rx_b1,
    output logic [7:0]  rx_b2,
    output logic        rx_b1_vld,
    output logic        rx_b2_vld,
    input  logic        bitclk_i,
    input  logic        slot1_sync_i,
    input  logic        slot2_sync_i,
    output logic        bitclk_o,
    output logic        slot1_sync_o,
    output logic        slot2_sync_o,
    output logic        timing_oe,
    input  logic        ser_di,
    output logic        ser_do,
    output logic        ser_doe
);
    localparam int unsigned IN_W = 4;
    localparam int unsigned I_CLK = 0;
    localparam int unsigned I_S1  = 1;
    localparam int unsigned I_S2  = 2;
    localparam int unsigned I_DAT = 3;

    logic g_rise, g_fall, g_s1, g_s2;
    logic [IN_W-1:0] sy_now, sy_prev;
    logic e_rise, e_fall, e_s1, e_s2, e_sd;

    bsp_clkgen #(.HALF0(HALF0)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_clk_master),
        .late     (cfg_late_data),
        .rate     (cfg_clk_sel),
        .rise_o   (g_rise),
        .fall_o   (g_fall),
        .s1_nx    (g_s1),
        .s2_nx    (g_s2),
        .bclk_q_o (bitclk_o),
        .s1_q_o   (slot1_sync_o),
        .s2_q_o   (slot2_sync_o)
    );

    bsp_in_sync #(.STAGES(SYNC_STAGES), .W(IN_W)) u_in_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_di, slot2_sync_i, slot1_sync_i, bitclk_i}),
        .dout  (sy_now),
        .dprev (sy_prev)
    );

    always_comb begin
        if (cfg_clk_master) begin
            e_rise = g_rise;
            e_fall = g_fall;
            e_s1   = g_s1;
            e_s2   = g_s2;
            e_sd   = ser_di;
        end else begin
            e_rise = sy_now[I_CLK] && !sy_prev[I_CLK];
            e_fall = !sy_now[I_CLK] && sy_prev[I_CLK];
            e_s1   = sy_now[I_S1];
            e_s2   = sy_now[I_S2];
            e_sd   = sy_now[I_DAT];
        end
    end

    bsp_slot_engine u_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (e_rise),
        .fall  (e_fall),
        .sync1 (e_s1),
        .sync2 (e_s2),
        .sdi   (e_sd),
        .late  (cfg_late_data),
        .swap  (cfg_swap_ch),
        .tx1   (tx_b1),
        .tx2   (tx_b2),
        .sdo   (ser_do),
        .sdoe  (ser_doe),
        .rx1   (rx_b1),
        .rx2   (rx_b2),
        .v1    (rx_b1_vld),
        .v2    (rx_b2_vld)
    );

    assign timing_oe = cfg_clk_master;

    // R2
    slave_outputs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_clk_master && !timing_oe) |=> !(slot1_sync_o || slot2_sync_o));
endmodule

// File: tb/bchan_serial_port_bench.sv
`timescale 1ns/1ps
module bchan_serial_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       cfg_clk_master = 1'b0, cfg_late_data = 1'b0, cfg_swap_ch = 1'b0;
    logic [2:0] cfg_clk_sel = 3'd0;
    logic [7:0] tx_b1 = 8'h00, tx_b2 = 8'h00;
    logic [7:0] rx_b1, rx_b2;
    logic       rx_b1_vld, rx_b2_vld;
    logic       bitclk_i = 1'b0, slot1_sync_i = 1'b0, slot2_sync_i = 1'b0;
    logic       bitclk_o, slot1_sync_o, slot2_sync_o, timing_oe;
    logic       ser_di, ser_do, ser_doe;
    logic       far_sd = 1'b0, sl_sd = 1'b0;

    assign ser_di = cfg_clk_master ? far_sd : sl_sd;

    bchan_serial_port u_bchan_serial_port (
        .clk(clk), .rst_n(rst_n),
        .cfg_clk_master(cfg_clk_master), .cfg_late_data(cfg_late_data),
        .cfg_swap_ch(cfg_swap_ch), .cfg_clk_sel(cfg_clk_sel),
        .tx_b1(tx_b1), .tx_b2(tx_b2), .rx_b1(rx_b1), .rx_b2(rx_b2),
        .rx_b1_vld(rx_b1_vld), .rx_b2_vld(rx_b2_vld),
        .bitclk_i(bitclk_i), .slot1_sync_i(slot1_sync_i), .slot2_sync_i(slot2_sync_i),
        .bitclk_o(bitclk_o), .slot1_sync_o(slot1_sync_o), .slot2_sync_o(slot2_sync_o),
        .timing_oe(timing_oe), .ser_di(ser_di), .ser_do(ser_do), .ser_doe(ser_doe)
    );

    int total = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // far end for master mode
    logic [7:0] far1 = 8'h00, far2 = 8'h00, cap1 = 8'h00, cap2 = 8'h00, cap_sh = 8'h00;
    int  fslot = 0, fbit = 0, fpend = 0, oe_err = 0, v1c = 0, v2c = 0;
    logic mon_on = 1'b0;

    initial begin
        forever begin
            int st;
            @(posedge bitclk_o); #1;
            if (!cfg_late_data) st = slot1_sync_o ? 1 : (slot2_sync_o ? 2 : 0);
            else                st = fpend;
            fpend = slot1_sync_o ? 1 : (slot2_sync_o ? 2 : 0);
            if (st != 0) begin fslot = st; fbit = 0; end
            else if (fslot != 0) begin fbit++; if (fbit == 8) fslot = 0; end
            if (fslot == 1)      far_sd = far1[3'(7 - fbit)];
            else if (fslot == 2) far_sd = far2[3'(7 - fbit)];
            else                 far_sd = 1'b0;
        end
    end

    initial begin
        forever begin
            @(negedge bitclk_o); #1;
            if (mon_on) begin
                if (fslot != 0) begin
                    if (ser_doe !== 1'b1) oe_err++;
                    cap_sh = {cap_sh[6:0], ser_do};
                    if (fbit == 7) begin
                        if (fslot == 1) cap1 = cap_sh; else cap2 = cap_sh;
                    end
                end else if (ser_doe !== 1'b0) oe_err++;
            end
        end
    end

    always @(posedge clk) if (mon_on) begin
        if (rx_b1_vld) v1c <= v1c + 1;
        if (rx_b2_vld) v2c <= v2c + 1;
    end

    // vector: late, swap, rate, tx1, tx2, far1, far2, exp slot1, exp slot2, exp rx1, exp rx2
    localparam int NV = 6;
    localparam logic [68:0] VECS [0:NV-1] = '{
        {1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C, 8'h96, 8'h0F, 8'hA5, 8'h3C, 8'h96, 8'h0F},
        {1'b0, 1'b1, 3'd1, 8'h81, 8'h7E, 8'hC3, 8'h18, 8'h7E, 8'h81, 8'h18, 8'hC3},
        {1'b1, 1'b0, 3'd2, 8'h12, 8'hEF, 8'h55, 8'hAA, 8'h12, 8'hEF, 8'h55, 8'hAA},
        {1'b1, 1'b1, 3'd3, 8'hFF, 8'h00, 8'h01, 8'h80, 8'h00, 8'hFF, 8'h80, 8'h01},
        {1'b0, 1'b0, 3'd4, 8'h6B, 8'hD4, 8'hE7, 8'h24, 8'h6B, 8'hD4, 8'hE7, 8'h24},
        {1'b1, 1'b0, 3'd7, 8'h0F, 8'hF0, 8'h3A, 8'hC5, 8'h0F, 8'hF0, 8'h3A, 8'hC5}
    };

    // slave-mode frame driven by the bench
    localparam int SH = 16;
    logic [7:0] sl_cap1 = 8'h00, sl_cap2 = 8'h00;
    int sl_oe_err = 0, sl_out_err = 0;

    task automatic slave_frame(input logic late, input logic [7:0] fa, input logic [7:0] fb);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            slot1_sync_i = late ? (k == 31) : (k == 0);
            slot2_sync_i = late ? (k == 7)  : (k == 8);
            sl_sd = (k < 8) ? fa[3'(7 - k)] : ((k < 16) ? fb[3'(15 - k)] : 1'b0);
            bitclk_i = 1'b1;
            repeat (SH) @(negedge clk);
            if (k < 8)       sl_cap1 = {sl_cap1[6:0], ser_do};
            else if (k < 16) sl_cap2 = {sl_cap2[6:0], ser_do};
            if (ser_doe !== (k < 16)) sl_oe_err++;
            if (bitclk_o || slot1_sync_o || slot2_sync_o || timing_oe) sl_out_err++;
            bitclk_i = 1'b0;
            repeat (SH - 1) @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int t0, n;
        logic [68:0] v;
        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 rx regs", {rx_b1, rx_b2}, 16'h0);
        chk("R10 valids and oe", {rx_b1_vld, rx_b2_vld, ser_doe}, 3'b000);
        chk("R10 timing outputs", {bitclk_o, slot1_sync_o, slot2_sync_o}, 3'b000);
        chk("R2 timing_oe slave", timing_oe, 1'b0);

        // table of master-mode vectors: R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            cfg_late_data = v[68]; cfg_swap_ch = v[67]; cfg_clk_sel = v[66:64];
            tx_b1 = v[63:56]; tx_b2 = v[55:48]; far1 = v[47:40]; far2 = v[39:32];
            cfg_clk_master = 1'b1;
            repeat (3) @(posedge slot1_sync_o);
            oe_err = 0; v1c = 0; v2c = 0; cap1 = 8'hxx; cap2 = 8'hxx;
            mon_on = 1'b1;
            @(posedge slot1_sync_o);
            #2 mon_on = 1'b0;
            chk($sformatf("R6 R7 slot1 byte vec%0d", i), cap1, v[31:24]);
            chk($sformatf("R6 R7 slot2 byte vec%0d", i), cap2, v[23:16]);
            chk($sformatf("R7 R8 rx_b1 vec%0d", i), rx_b1, v[15:8]);
            chk($sformatf("R7 R8 rx_b2 vec%0d", i), rx_b2, v[7:0]);
            chk($sformatf("R9 oe window vec%0d", i), oe_err, 0);
            chk($sformatf("R8 one pulse each vec%0d", i), {v1c[7:0], v2c[7:0]}, 16'h0101);
        end

        // R1: bit-clock period and frame length
        cfg_late_data = 1'b0; cfg_clk_sel = 3'd2;
        repeat (2) @(posedge slot1_sync_o);
        @(posedge bitclk_o); t0 = cyc; @(posedge bitclk_o);
        chk("R1 period code2", cyc - t0, 16);
        cfg_clk_sel = 3'd6;
        repeat (2) @(posedge slot1_sync_o);
        @(posedge bitclk_o); t0 = cyc; @(posedge bitclk_o);
        chk("R1 period clamped code6", cyc - t0, 4);
        cfg_clk_sel = 3'd1;
        repeat (2) @(posedge slot1_sync_o);
        n = 0;
        fork
            begin @(posedge slot1_sync_o); end
            forever begin @(posedge bitclk_o); n++; end
        join_any
        disable fork;
        chk("R1 frame bits code1", n, 64);
        // R3: strobe width and slot 2 offset
        @(posedge slot1_sync_o); t0 = cyc; @(negedge slot1_sync_o);
        chk("R3 strobe width", cyc - t0, 2 * (32 >> 1));
        @(posedge slot1_sync_o); t0 = cyc; @(posedge slot2_sync_o);
        chk("R3 slot2 offset", cyc - t0, 8 * 2 * (32 >> 1));

        // slave mode, non-delayed (R2 R4) then delayed with swap (R5 R7)
        @(negedge clk);
        cfg_clk_master = 1'b0; cfg_late_data = 1'b0; cfg_swap_ch = 1'b0;
        tx_b1 = 8'hC6; tx_b2 = 8'h39;
        repeat (10) @(negedge clk);
        sl_oe_err = 0; sl_out_err = 0;
        slave_frame(1'b0, 8'h5A, 8'hB1);
        repeat (4) @(negedge clk);
        chk("R4 slave slot1 tx", sl_cap1, 8'hC6);
        chk("R4 slave slot2 tx", sl_cap2, 8'h39);
        chk("R4 slave rx_b1", rx_b1, 8'h5A);
        chk("R4 slave rx_b2", rx_b2, 8'hB1);
        chk("R2 slave outputs quiet", sl_out_err, 0);
        chk("R9 slave oe window", sl_oe_err, 0);

        cfg_late_data = 1'b1; cfg_swap_ch = 1'b1;
        slave_frame(1'b1, 8'h00, 8'h00);
        sl_oe_err = 0;
        slave_frame(1'b1, 8'h4D, 8'hE2);
        repeat (4) @(negedge clk);
        chk("R5 slave slot1 tx swapped", sl_cap1, 8'h39);
        chk("R5 slave slot2 tx swapped", sl_cap2, 8'hC6);
        chk("R5 R7 slave rx_b2", rx_b2, 8'h4D);
        chk("R5 R7 slave rx_b1", rx_b1, 8'hE2);
        chk("R9 slave late oe window", sl_oe_err, 0);

        finish_run();
    end
endmodule